// File: doc/BRIEF.md
# Programmable Parallel CRC Engine

This block keeps a running cyclic redundancy check over a stream of data beats. Each clock it can take one beat of 8, 16 or 32 bits and advance the check value by that many bit steps at once. The shift register uses internal (Galois) feedback, so the value held after the last beat is already the finished check, and no trailing zero bits need to be fed. The generator polynomial is not fixed. Two polynomial inputs, A and B, are sampled live. A three-bit mode code picks the polynomial length (16 or 32 bits) and which of the two inputs is used.

Memory is little-endian, and wider beats carry their lowest-addressed byte in the low lane. The engine puts the lanes into address order before it folds them in. As a result, one byte sequence gives one check value whether it arrives as bytes, halfwords or words. A synchronous init pulse loads a seed. Software-facing register decode and bus logic sit outside this block.

Top module: `pcrc_core`

## Requirements
- R1: Reset clears the check value to zero. When `init_i` is high, the next edge loads `seed_i`, or only its low 16 bits with the upper half zeroed when the mode code selects a 16-bit polynomial. Init takes priority over `valid_i`.
- R2: When `init_i` and `valid_i` are both low, the check value is held.
- R3: Mode codes select the polynomial: 3'b110 means 32-bit using `poly_a_i`, 3'b101 means 32-bit using `poly_b_i`, 3'b011 means 16-bit using `poly_a_i`, and 3'b010 means 16-bit using `poly_b_i`.
- R4: A beat presented with any other mode code (000, 001, 100, 111) leaves the check value unchanged.
- R5: Width codes: 0 means one byte in `data_i[7:0]`, 1 means a halfword in `data_i[15:0]`, and 2 means a word in `data_i[31:0]`. Code 3 leaves the check value unchanged.
- R6: Each data bit b updates the state as follows. For length L, with fb = state[L-1] ^ b, the state shifts left one place within L bits and is then XORed with the polynomial if fb is 1. Polynomial bit k is the coefficient of x^k. The x^L term is implicit, and bit 0 is always treated as 1 whatever its value.
- R7: Bytes are folded in lane-address order: lane 0 (`data_i[7:0]`) first, then lane 1, and so on. Within a byte, bit 7 goes first. The same byte sequence gives identical results when fed in byte, halfword or word beats.
- R8: In 16-bit modes, only the low 16 bits of the polynomial and the seed matter, and `crc_o[31:15+1]` reads zero after any beat.
- R9: An accepted beat changes `crc_o` on the same clock edge that samples it. Every width works with every polynomial length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | Load seed on next edge |
| seed_i | input | 32 | Seed value |
| poly_a_i | input | 32 | Polynomial input A |
| poly_b_i | input | 32 | Polynomial input B |
| mode_i | input | 3 | Polynomial length and selector code |
| width_i | input | 2 | Beat width code |
| valid_i | input | 1 | Beat present |
| data_i | input | 32 | Beat data, little-endian lanes |
| crc_o | output | 32 | Current check value |

## Verification
The bench builds the engine with its default parameters: 8-bit lanes and four lanes, which gives width codes 0 to 2 and a 32-step feedback chain. At this size, every single-byte value can be swept under both polynomial lengths. All four mode codes can be crossed with all three beat widths under random polynomials. A byte stream can be fed at each width and compared, and the ignored codes, idle cycles and init priority can be observed directly at `crc_o`.

// File: rtl/pcrc_pkg.sv
// Shared constants, mode codes and the single-bit Galois step for the CRC engine.
// Assumes the check value register is always 32 bits wide; 16-bit modes use the low half.
package pcrc_pkg;

    localparam int CRC_W  = 32;
    localparam int HALF_W = 16;

    typedef enum logic [2:0] {
        MODE_P16B = 3'b010,
        MODE_P16A = 3'b011,
        MODE_P32B = 3'b101,
        MODE_P32A = 3'b110
    } pcrc_mode_e;

    // One Galois step: feed bit b into state s under polynomial p.
    function automatic logic [CRC_W-1:0] crc_step(
        input logic [CRC_W-1:0] s,
        input logic [CRC_W-1:0] p,
        input logic             len32,
        input logic             b
    );
        logic [CRC_W-1:0] pe;
        logic             fb;
        logic [CRC_W-1:0] n;
        pe = p | CRC_W'(1);
        if (len32) begin
            fb = s[CRC_W-1] ^ b;
            n  = {s[CRC_W-2:0], 1'b0};
            if (fb) n = n ^ pe;
        end else begin
            fb = s[HALF_W-1] ^ b;
            n  = {{(CRC_W-HALF_W){1'b0}}, s[HALF_W-2:0], 1'b0};
            if (fb) n = n ^ {{(CRC_W-HALF_W){1'b0}}, pe[HALF_W-1:0]};
        end
        return n;
    endfunction

endpackage

// File: rtl/pcrc_mode_dec.sv
// Decodes the three-bit mode code into a hit flag, the polynomial length
// and the chosen polynomial. Assumes unknown codes must not update state.
module pcrc_mode_dec
    import pcrc_pkg::*;
(
    input  logic [2:0]       mode_i,
    input  logic [CRC_W-1:0] poly_a_i,
    input  logic [CRC_W-1:0] poly_b_i,
    output logic             hit_o,
    output logic             len32_o,
    output logic [CRC_W-1:0] poly_o
);

    // Map each legal code onto length and register choice.
    always_comb begin
        hit_o   = 1'b1;
        len32_o = 1'b1;
        poly_o  = poly_a_i;
        case (mode_i)
            MODE_P32A: begin len32_o = 1'b1; poly_o = poly_a_i; end
            MODE_P32B: begin len32_o = 1'b1; poly_o = poly_b_i; end
            MODE_P16A: begin len32_o = 1'b0; poly_o = poly_a_i; end
            MODE_P16B: begin len32_o = 1'b0; poly_o = poly_b_i; end
            default:   begin hit_o = 1'b0; end
        endcase
    end

endmodule

// File: rtl/pcrc_lane_order.sv
// Places the lanes of one beat into processing order: lane 0 first, in the
// top slot of the message word, since the chain consumes MSB first.
// Unused slots are zero; the chain tap for the width ignores them anyway.
module pcrc_lane_order #(
    parameter int LANE_W  = 8,
    parameter int LANES   = 4,
    parameter int WCODE_W = 2,
    localparam int DATA_W = LANE_W * LANES
) (
    input  logic [DATA_W-1:0]  data_i,
    input  logic [WCODE_W-1:0] width_i,
    output logic [DATA_W-1:0]  msg_o
);

    logic [LANES:0] used_cnt;

    // Number of lanes present in this beat.
    always_comb used_cnt = (LANES+1)'(1) << width_i;

    // Reverse lane order into the message slots.
    genvar j;
    generate
        for (j = 0; j < LANES; j++) begin : g_slot
            always_comb begin
                if ((LANES+1)'(j) < used_cnt)
                    msg_o[DATA_W-1-j*LANE_W -: LANE_W] = data_i[j*LANE_W +: LANE_W];
                else
                    msg_o[DATA_W-1-j*LANE_W -: LANE_W] = '0;
            end
        end
    endgenerate

endmodule

// File: rtl/pcrc_chain.sv
// Unrolled chain of single-bit Galois steps. Tap i holds the state after
// the first i message bits (taken from the MSB down) have been folded in.
module pcrc_chain
    import pcrc_pkg::*;
#(
    parameter int STEPS = 32
) (
    input  logic [CRC_W-1:0]             state_i,
    input  logic [CRC_W-1:0]             poly_i,
    input  logic                         len32_i,
    input  logic [STEPS-1:0]             msg_i,
    output logic [STEPS:0][CRC_W-1:0]    taps_o
);

    // Starting point of the chain.
    always_comb taps_o[0] = state_i;

    genvar i;
    generate
        for (i = 0; i < STEPS; i++) begin : g_step
            // One bit of feedback per stage.
            always_comb taps_o[i+1] = crc_step(taps_o[i], poly_i, len32_i, msg_i[STEPS-1-i]);
        end
    endgenerate

endmodule

// File: rtl/pcrc_core.sv
// Parallel CRC engine top. Holds the check value, loads the seed on init,
// and folds in one beat of 1, 2 or 4 lanes per accepted cycle.
// Assumes synchronous active-low reset and that the mode code and polynomials
// are stable while a beat is presented.
module pcrc_core
    import pcrc_pkg::*;
#(
    parameter int LANE_W  = 8,
    parameter int LANES   = 4,
    parameter int WCODE_W = 2,
    localparam int DATA_W = LANE_W * LANES,
    localparam int NCODES = $clog2(LANES) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic [CRC_W-1:0]   seed_i,
    input  logic [CRC_W-1:0]   poly_a_i,
    input  logic [CRC_W-1:0]   poly_b_i,
    input  logic [2:0]         mode_i,
    input  logic [WCODE_W-1:0] width_i,
    input  logic               valid_i,
    input  logic [DATA_W-1:0]  data_i,
    output logic [CRC_W-1:0]   crc_o
);

    logic                       mode_hit;
    logic                       len32;
    logic [CRC_W-1:0]           poly_sel;
    logic [DATA_W-1:0]          msg;
    logic [DATA_W:0][CRC_W-1:0] taps;
    logic [CRC_W-1:0]           state_q;
    logic [CRC_W-1:0]           next_state;
    logic                       width_ok;
    logic [CRC_W-1:0]           seed_masked;

    pcrc_mode_dec u_dec (
        .mode_i   (mode_i),
        .poly_a_i (poly_a_i),
        .poly_b_i (poly_b_i),
        .hit_o    (mode_hit),
        .len32_o  (len32),
        .poly_o   (poly_sel)
    );

    pcrc_lane_order #(
        .LANE_W  (LANE_W),
        .LANES   (LANES),
        .WCODE_W (WCODE_W)
    ) u_order (
        .data_i  (data_i),
        .width_i (width_i),
        .msg_o   (msg)
    );

    pcrc_chain #(
        .STEPS (DATA_W)
    ) u_chain (
        .state_i (state_q),
        .poly_i  (poly_sel),
        .len32_i (len32),
        .msg_i   (msg),
        .taps_o  (taps)
    );

    // Pick the chain tap matching the beat width; flag unsupported codes.
    always_comb begin
        next_state = state_q;
        width_ok   = 1'b0;
        for (int c = 0; c < NCODES; c++) begin
            if (width_i == WCODE_W'(c)) begin
                next_state = taps[LANE_W << c];
                width_ok   = 1'b1;
            end
        end
    end

    // Seed is cut to the low half when a 16-bit code is applied.
    always_comb seed_masked = (mode_hit && !len32) ?
                              {{(CRC_W-HALF_W){1'b0}}, seed_i[HALF_W-1:0]} : seed_i;

    // Check value register: reset, init, or accept a beat.
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else if (init_i)
            state_q <= seed_masked;
        else if (valid_i && mode_hit && width_ok)
            state_q <= next_state;
    end

    // Result is the live state.
    always_comb crc_o = state_q;

endmodule

// File: rtl/pcrc_core_chk.sv
// Port-level checker for pcrc_core, attached with bind below.
module pcrc_core_chk #(
    parameter int WCODE_W = 2,
    parameter int DATA_W  = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               init_i,
    input logic [31:0]        seed_i,
    input logic [2:0]         mode_i,
    input logic [WCODE_W-1:0] width_i,
    input logic               valid_i,
    input logic [31:0]        crc_o
);

    logic mode16;
    logic mode_legal;
    always_comb mode16     = (mode_i == 3'b011) || (mode_i == 3'b010);
    always_comb mode_legal = mode16 || (mode_i == 3'b110) || (mode_i == 3'b101);

    // R1
    init_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i && mode16 |=> crc_o == {16'h0, $past(seed_i[15:0])});

    // R1
    init_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_i && !mode16 |=> crc_o == $past(seed_i));

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i && !valid_i |=> $stable(crc_o));

    // R4
    bad_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i && valid_i && !mode_legal |=> $stable(crc_o));

    // R5
    bad_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i && valid_i && (width_i == 2'd3) |=> $stable(crc_o));

    // R8
    half_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init_i && valid_i && mode16 && (width_i != 2'd3) |=> crc_o[31:16] == 16'h0);

endmodule

bind pcrc_core pcrc_core_chk #(.WCODE_W(WCODE_W), .DATA_W(DATA_W)) u_pcrc_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .init_i  (init_i),
    .seed_i  (seed_i),
    .mode_i  (mode_i),
    .width_i (width_i),
    .valid_i (valid_i),
    .crc_o   (crc_o)
);

// File: tb/pcrc_core_test.sv
`timescale 1ns/1ps
module pcrc_core_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0;
    logic [31:0] seed_i = '0;
    logic [31:0] poly_a_i = '0;
    logic [31:0] poly_b_i = '0;
    logic [2:0]  mode_i = 3'b110;
    logic [1:0]  width_i = '0;
    logic        valid_i = 1'b0;
    logic [31:0] data_i = '0;
    logic [31:0] crc_o;

    int n_tests = 0;
    int n_fail  = 0;
    logic [31:0] exp_crc;

    always #2 clk = ~clk;

    pcrc_core uut (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .seed_i(seed_i),
        .poly_a_i(poly_a_i), .poly_b_i(poly_b_i), .mode_i(mode_i),
        .width_i(width_i), .valid_i(valid_i), .data_i(data_i), .crc_o(crc_o)
    );

    // Serial reference: fold one byte, bit 7 first.
    function automatic logic [31:0] ref_byte(input logic [31:0] s, input logic [31:0] p,
                                             input bit l32, input logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            logic fb;
            if (l32) begin
                fb = s[31] ^ b[i];
                s  = {s[30:0], 1'b0};
                if (fb) s = s ^ (p | 32'h1);
            end else begin
                fb = s[15] ^ b[i];
                s  = {16'h0, s[14:0], 1'b0};
                if (fb) s = s ^ {16'h0, p[15:0] | 16'h1};
            end
        end
        return s;
    endfunction

    function automatic bit is16(input logic [2:0] m);
        return (m == 3'b011) || (m == 3'b010);
    endfunction

    function automatic logic [31:0] cur_poly(input logic [2:0] m);
        return (m == 3'b110 || m == 3'b011) ? poly_a_i : poly_b_i;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %08h expected %08h", req, act, exp);
        end
    endtask

    task automatic do_init(input logic [31:0] seed, input logic [2:0] mode);
        @(negedge clk);
        init_i = 1'b1; seed_i = seed; mode_i = mode; valid_i = 1'b0;
        @(posedge clk); #1;
        init_i = 1'b0;
        exp_crc = is16(mode) ? {16'h0, seed[15:0]} : seed;
    endtask

    // Present one beat and update the expected value from the reference.
    task automatic beat(input logic [31:0] d, input logic [1:0] w, input string req);
        @(negedge clk);
        data_i = d; width_i = w; valid_i = 1'b1;
        @(posedge clk); #1;
        valid_i = 1'b0;
        if (w != 2'd3) begin
            for (int k = 0; k < (1 << w); k++)
                exp_crc = ref_byte(exp_crc, cur_poly(mode_i), !is16(mode_i), d[8*k +: 8]);
        end
        check(req, crc_o, exp_crc);
    endtask

    task automatic finish_run;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_tests++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    logic [7:0]  stream [12];
    logic [31:0] res_w [3];
    logic [2:0]  modes [4] = '{3'b110, 3'b101, 3'b011, 3'b010};
    logic [2:0]  bad_modes [4] = '{3'b000, 3'b001, 3'b100, 3'b111};

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R1 reset", crc_o, 32'h0);
        @(negedge clk); rst_n = 1'b1;

        // R6: exhaustive single bytes under both lengths
        poly_a_i = 32'h04C11DB7; poly_b_i = 32'h00001021;
        foreach (modes[mi]) begin
            for (int v = 0; v < 256; v++) begin
                do_init(32'hFFFFFFFF, modes[mi]);
                beat({24'h0, 8'(v)}, 2'd0, "R6 byte sweep");
            end
        end

        // R3 R9: every mode with every width, random polynomials
        for (int t = 0; t < 6; t++) begin
            poly_a_i = $urandom; poly_b_i = $urandom;
            foreach (modes[mi]) begin
                for (int w = 0; w < 3; w++) begin
                    do_init($urandom, modes[mi]);
                    for (int b = 0; b < 6; b++) beat($urandom, 2'(w), "R3 R9 combo");
                end
            end
        end

        // R3: A versus B selection gives distinct results for distinct polynomials
        poly_a_i = 32'h1EDC6F41; poly_b_i = 32'h04C11DB7;
        do_init(32'h0, 3'b110); beat(32'h000000A5, 2'd0, "R3 use A");
        res_w[0] = crc_o;
        do_init(32'h0, 3'b101); beat(32'h000000A5, 2'd0, "R3 use B");
        n_tests++;
        if (res_w[0] == crc_o) begin
            n_fail++;
            $display("FAIL R3: got %08h expected value differing from %08h", crc_o, res_w[0]);
        end

        // R7: one stream fed as bytes, halfwords, words
        for (int i = 0; i < 12; i++) stream[i] = 8'($urandom);
        foreach (modes[mi]) begin
            poly_a_i = $urandom; poly_b_i = $urandom;
            for (int w = 0; w < 3; w++) begin
                do_init(32'h5A5A1234, modes[mi]);
                for (int i = 0; i < 12; i += (1 << w)) begin
                    logic [31:0] d;
                    d = '0;
                    for (int k = 0; k < (1 << w); k++) d[8*k +: 8] = stream[i+k];
                    beat(d, 2'(w), "R7 stream");
                end
                res_w[w] = crc_o;
            end
            check("R7 half equals byte", res_w[1], res_w[0]);
            check("R7 word equals byte", res_w[2], res_w[0]);
        end

        // R6: bit 0 of the polynomial is ignored
        poly_a_i = 32'h04C11DB6;
        do_init(32'hFFFFFFFF, 3'b110); beat(32'h12345678, 2'd2, "R6 bit0 clear");
        res_w[0] = crc_o;
        poly_a_i = 32'h04C11DB7;
        do_init(32'hFFFFFFFF, 3'b110); beat(32'h12345678, 2'd2, "R6 bit0 set");
        check("R6 bit0 dont care", crc_o, res_w[0]);

        // R8: upper seed and polynomial bits ignored in 16-bit mode
        poly_a_i = 32'hDEAD8005;
        do_init(32'hBEEFFFFF, 3'b011);
        check("R8 seed masked", crc_o, 32'h0000FFFF);
        beat(32'hCAFEF00D, 2'd2, "R8 16-bit word");
        check("R8 upper zero", {16'h0, crc_o[31:16]}, 32'h0);

        // R4: unknown mode codes hold state
        do_init(32'h13579BDF, 3'b110);
        foreach (bad_modes[bi]) begin
            @(negedge clk);
            mode_i = bad_modes[bi]; data_i = $urandom; width_i = 2'd2; valid_i = 1'b1;
            @(posedge clk); #1; valid_i = 1'b0;
            check("R4 bad mode hold", crc_o, 32'h13579BDF);
        end

        // R5: width code 3 holds state
        do_init(32'h2468ACE0, 3'b110);
        beat(32'hFFFFFFFF, 2'd3, "R5 width3 hold");

        // R2: idle cycles hold state
        @(negedge clk); data_i = 32'hFFFFFFFF; width_i = 2'd2; valid_i = 1'b0;
        repeat (3) @(posedge clk); #1;
        check("R2 idle hold", crc_o, 32'h2468ACE0);

        // R1: init wins over a simultaneous beat
        @(negedge clk);
        init_i = 1'b1; seed_i = 32'h0F0F0F0F; valid_i = 1'b1; data_i = 32'h11;
        @(posedge clk); #1;
        init_i = 1'b0; valid_i = 1'b0;
        check("R1 init priority", crc_o, 32'h0F0F0F0F);

        finish_run();
    end

endmodule